// File: doc/BRIEF.md
# Input Voltage Status Register With Alert Output

This block holds a one-byte status register that reports the health of a supply's input voltage. Two comparator event strobes feed it: an overvoltage fault and an undervoltage warning. Each strobe sets a sticky flag that stays set until software clears it. A third input is a live level that is high while input power sits inside its operating window. The register shows the inverse of that level as a non-sticky "input low" bit. The byte can be read at any time on a plain read port.

Software clears the sticky flags in two ways. It can write ones to individual flag positions on command code 0x7C, or it can pulse a global clear-faults strobe. A separate mask register decides which sticky flags may pull the active-low alert line. The alert is asserted (driven to 0) while any unmasked sticky flag is set. The undervoltage warning stays disarmed after reset until the input has been seen on once. This keeps the normal power-up ramp from raising a spurious warning. Bus transaction decoding and the analog comparators sit outside the block, and simple strobes stand in for them.

Top module: `vin_input_status`

## Requirements
- R1: In the cycle after reset is released with the input-on level low, rd_data_o reads 0x08 and alert_n_o reads 1. Reset clears both sticky flags and both mask bits, and sets the input-low bit (bit 3) to 1.
- R2: Bits 6, 4, 2, 1 and 0 of rd_data_o always read 0.
- R3: A write with bus_wr_i high and bus_cmd_i equal to 0x7C clears the overvoltage flag (bit 7) when bus_wdata_i[7] is 1. It clears the undervoltage flag (bit 5) when bus_wdata_i[5] is 1. A flag whose data bit is 0 keeps its value.
- R4: A pulse on clr_faults_i clears both sticky flags at the next clock edge.
- R5: Bit 3 is not sticky. After each clock edge it equals the inverse of the vin_on_i value sampled at that edge.
- R6: While vin_on_i has never been sampled high since reset, undervoltage strobes are ignored and bit 5 stays 0. Sampling vin_on_i high arms the warning from the following edge onward, and it stays armed until the next reset.
- R7: An overvoltage strobe sets bit 7 at the same edge. An armed undervoltage strobe sets bit 5 at the same edge.
- R8: A write on mask_wr_i loads the mask from mask_wdata_i. A 1 in bit 7 masks the overvoltage flag, and a 1 in bit 5 masks the undervoltage flag. A masked flag still latches and reads back, but does not assert the alert.
- R9: When a strobe and a clear (either kind) for the same flag occur in the same cycle, the flag is set after that edge.
- R10: alert_n_o is a registered output. It is 0 in the cycle after any sticky flag is set while its mask bit is 0. It returns to 1 in the cycle after the last such flag is cleared or masked.
- R11: Writes whose bus_cmd_i differs from 0x7C leave both sticky flags unchanged.
- R12: The input-low bit never drives alert_n_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovf_evt_i | input | 1 | Input overvoltage fault strobe |
| uvw_evt_i | input | 1 | Input undervoltage warning strobe |
| vin_on_i | input | 1 | Live level, 1 while input power is on |
| bus_wr_i | input | 1 | Byte write strobe |
| bus_cmd_i | input | 8 | Command code of the write |
| bus_wdata_i | input | 8 | Write data, ones select flags to clear |
| clr_faults_i | input | 1 | Global clear of all sticky flags |
| mask_wr_i | input | 1 | Mask register load strobe |
| mask_wdata_i | input | 8 | Mask value, bits 7 and 5 used |
| rd_data_o | output | 8 | Status byte |
| alert_n_o | output | 1 | Active-low alert, open-drain style |

## Verification
Directed sequences come first. They strobe undervoltage before the input has ever been on, which separates a working arming gate from a missing one. They write zeros and then ones on the right command code and on a wrong one, which separates per-bit clearing from whole-register clearing and from address-blind decoding. They collide a strobe with both kinds of clear in one cycle, which shows whether events take priority. They toggle the mask while flags are set, which shows that latching and alerting are independent. Random cycles then mix all inputs with sparse strobes. A cycle model of the requirements compares every status field and the alert line each cycle, which exposes off-by-one timing on the live bit and on the alert.

// File: rtl/vin_stat_pkg.sv
package vin_stat_pkg;
  localparam int STAT_W   = 8;
  localparam int CMD_W    = 8;
  localparam int NUM_FLAG = 2;
  localparam int OVF_POS  = 7;
  localparam int UVW_POS  = 5;
  localparam int LOW_POS  = 3;
  localparam logic [CMD_W-1:0] STATUS_CMD = 8'h7C;

  typedef logic [STAT_W-1:0] stat_byte_t;

  // index 0 = overvoltage flag, index 1 = undervoltage flag
  function automatic int flag_pos(input int idx);
    return (idx == 0) ? OVF_POS : UVW_POS;
  endfunction
endpackage

// File: rtl/vin_sticky_flag.sv
module vin_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // A set in the same cycle as a clear keeps the flag set.
  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/vin_uv_arm.sv
module vin_uv_arm (
  input  logic clk,
  input  logic rst,
  input  logic vin_on_i,
  input  logic uv_evt_i,
  output logic armed_o,
  output logic uv_evt_o
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst)           armed_q <= 1'b0;
    else if (vin_on_i) armed_q <= 1'b1;
  end

  assign armed_o  = armed_q;
  assign uv_evt_o = uv_evt_i & armed_q;
endmodule

// File: rtl/vin_alert_gen.sv
module vin_alert_gen #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mask_wr_i,
  input  logic [N-1:0] mask_bits_i,
  input  logic [N-1:0] flags_i,
  output logic [N-1:0] mask_o,
  output logic         alert_n_o
);
  logic [N-1:0] mask_q;
  logic         alert_n_q;
  logic         any_live;

  always_ff @(posedge clk) begin
    if (rst)            mask_q <= '0;
    else if (mask_wr_i) mask_q <= mask_bits_i;
  end

  assign any_live = |(flags_i & ~mask_q);

  always_ff @(posedge clk) begin
    if (rst) alert_n_q <= 1'b1;
    else     alert_n_q <= ~any_live;
  end

  assign mask_o    = mask_q;
  assign alert_n_o = alert_n_q;
endmodule

// File: rtl/vin_input_status.sv
module vin_input_status
  import vin_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ovf_evt_i,
  input  logic              uvw_evt_i,
  input  logic              vin_on_i,
  input  logic              bus_wr_i,
  input  logic [CMD_W-1:0]  bus_cmd_i,
  input  logic [STAT_W-1:0] bus_wdata_i,
  input  logic              clr_faults_i,
  input  logic              mask_wr_i,
  input  logic [STAT_W-1:0] mask_wdata_i,
  output logic [STAT_W-1:0] rd_data_o,
  output logic              alert_n_o
);
  logic                addr_hit;
  logic                uv_armed;
  logic                uv_gated;
  logic                low_q;
  logic [NUM_FLAG-1:0] evt_vec;
  logic [NUM_FLAG-1:0] flag_vec;
  logic [NUM_FLAG-1:0] mask_in;
  logic [NUM_FLAG-1:0] mask_q;
  stat_byte_t          stat_byte;

  assign addr_hit = bus_wr_i && (bus_cmd_i == STATUS_CMD);

  vin_uv_arm u_arm (
    .clk      (clk),
    .rst      (rst),
    .vin_on_i (vin_on_i),
    .uv_evt_i (uvw_evt_i),
    .armed_o  (uv_armed),
    .uv_evt_o (uv_gated)
  );

  assign evt_vec = {uv_gated, ovf_evt_i};

  for (genvar g = 0; g < NUM_FLAG; g++) begin : g_flag
    localparam int POS = flag_pos(g);
    logic clr_this;
    assign clr_this   = clr_faults_i | (addr_hit & bus_wdata_i[POS]);
    assign mask_in[g] = mask_wdata_i[POS];
    vin_sticky_flag u_flag (
      .clk    (clk),
      .rst    (rst),
      .set_i  (evt_vec[g]),
      .clr_i  (clr_this),
      .flag_o (flag_vec[g])
    );
  end

  vin_alert_gen #(.N(NUM_FLAG)) u_alert (
    .clk         (clk),
    .rst         (rst),
    .mask_wr_i   (mask_wr_i),
    .mask_bits_i (mask_in),
    .flags_i     (flag_vec),
    .mask_o      (mask_q),
    .alert_n_o   (alert_n_o)
  );

  // Live input-low bit, registered; reads 1 out of reset.
  always_ff @(posedge clk) begin
    if (rst) low_q <= 1'b1;
    else     low_q <= ~vin_on_i;
  end

  always_comb begin
    stat_byte          = '0;
    stat_byte[LOW_POS] = low_q;
    for (int i = 0; i < NUM_FLAG; i++) stat_byte[flag_pos(i)] = flag_vec[i];
  end

  assign rd_data_o = stat_byte;
endmodule

// File: rtl/vin_input_status_chk.sv
module vin_input_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       ovf_evt_i,
  input logic       uvw_evt_i,
  input logic       vin_on_i,
  input logic       bus_wr_i,
  input logic [7:0] bus_cmd_i,
  input logic       clr_faults_i,
  input logic [7:0] rd_data_o,
  input logic       alert_n_o,
  input logic [1:0] mask_q,
  input logic       uv_armed
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_data_o[6] == 1'b0) && (rd_data_o[4] == 1'b0) && (rd_data_o[2:0] == 3'b000));

  a_r5_low_live: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rd_data_o[3] == !$past(vin_on_i)));

  a_r6_disarmed_quiet: assert property (@(posedge clk) disable iff (rst)
    !uv_armed |=> !rd_data_o[5]);

  a_r7_ovf_sets: assert property (@(posedge clk) disable iff (rst)
    ovf_evt_i |=> rd_data_o[7]);

  a_r4_clear_all: assert property (@(posedge clk) disable iff (rst)
    (clr_faults_i && !ovf_evt_i && !uvw_evt_i) |=> (!rd_data_o[7] && !rd_data_o[5]));

  a_r10_alert_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (alert_n_o == !$past(|({rd_data_o[5], rd_data_o[7]} & ~mask_q))));

  a_r11_other_cmd: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_i && bus_cmd_i != 8'h7C && !clr_faults_i && !ovf_evt_i) |=> (rd_data_o[7] == $past(rd_data_o[7])));
endmodule

bind vin_input_status vin_input_status_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .ovf_evt_i    (ovf_evt_i),
  .uvw_evt_i    (uvw_evt_i),
  .vin_on_i     (vin_on_i),
  .bus_wr_i     (bus_wr_i),
  .bus_cmd_i    (bus_cmd_i),
  .clr_faults_i (clr_faults_i),
  .rd_data_o    (rd_data_o),
  .alert_n_o    (alert_n_o),
  .mask_q       (mask_q),
  .uv_armed     (uv_armed)
);

// File: tb/vin_input_status_tb_top.sv
module vin_input_status_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ovf_evt = 0, uvw_evt = 0, vin_on = 0;
  logic       bus_wr = 0, clr_faults = 0, mask_wr = 0;
  logic [7:0] bus_cmd = 0, bus_wdata = 0, mask_wdata = 0;
  logic [7:0] rd_data;
  logic       alert_n;

  int checks = 0;
  int errors = 0;
  string cur_tag = "";

  // reference state
  bit m_ovf, m_uv, m_low, m_armed, m_mk_ovf, m_mk_uv, m_alert_n;

  always #2 clk = ~clk;

  vin_input_status dut_i (
    .clk(clk), .rst(rst), .ovf_evt_i(ovf_evt), .uvw_evt_i(uvw_evt),
    .vin_on_i(vin_on), .bus_wr_i(bus_wr), .bus_cmd_i(bus_cmd),
    .bus_wdata_i(bus_wdata), .clr_faults_i(clr_faults), .mask_wr_i(mask_wr),
    .mask_wdata_i(mask_wdata), .rd_data_o(rd_data), .alert_n_o(alert_n)
  );

  function automatic bit next_flag(bit cur, bit set, bit clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic [7:0] exp_byte();
    return {m_ovf, 1'b0, m_uv, 1'b0, m_low, 3'b000};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, cur_tag, act, exp);
    end
  endtask

  task automatic compare();
    logic [7:0] e = exp_byte();
    chk("R3/R4/R7/R9/R11 bit7", {7'd0, rd_data[7]}, {7'd0, e[7]});
    chk("R6/R7/R3 bit5",        {7'd0, rd_data[5]}, {7'd0, e[5]});
    chk("R5 bit3",              {7'd0, rd_data[3]}, {7'd0, e[3]});
    chk("R2 reserved",          rd_data & 8'h57,    8'h00);
    chk("R8/R10/R12 alert",     {7'd0, alert_n},    {7'd0, m_alert_n});
  endtask

  task automatic step();
    bit clr7, clr5, hit;
    @(posedge clk);
    #1;
    if (rst) begin
      m_ovf = 0; m_uv = 0; m_low = 1; m_armed = 0;
      m_mk_ovf = 0; m_mk_uv = 0; m_alert_n = 1;
    end else begin
      m_alert_n = !((m_ovf && !m_mk_ovf) || (m_uv && !m_mk_uv));
      hit  = bus_wr && (bus_cmd == 8'h7C);
      clr7 = clr_faults || (hit && bus_wdata[7]);
      clr5 = clr_faults || (hit && bus_wdata[5]);
      m_ovf = next_flag(m_ovf, ovf_evt, clr7);
      m_uv  = next_flag(m_uv, uvw_evt && m_armed, clr5);
      if (vin_on) m_armed = 1;
      m_low = !vin_on;
      if (mask_wr) begin m_mk_ovf = mask_wdata[7]; m_mk_uv = mask_wdata[5]; end
    end
    @(negedge clk);
    if (!rst) compare();
  endtask

  task automatic idle();
    ovf_evt = 0; uvw_evt = 0; bus_wr = 0; clr_faults = 0; mask_wr = 0;
    bus_cmd = 0; bus_wdata = 0; mask_wdata = 0;
  endtask

  task automatic w1c(logic [7:0] cmd, logic [7:0] d);
    bus_wr = 1; bus_cmd = cmd; bus_wdata = d; step(); idle();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    process::self().srandom(32'd2024);
    @(negedge clk);
    rst = 1; step(); step();
    rst = 0; step();
    cur_tag = "R1 reset";
    chk("R1 byte", rd_data, 8'h08);
    chk("R1 alert", {7'd0, alert_n}, 8'h01);

    cur_tag = "R6 disarmed";
    uvw_evt = 1; step(); idle(); step();
    chk("R6 bit5 ignored", rd_data & 8'h20, 8'h00);

    cur_tag = "R7 ovf";
    ovf_evt = 1; step(); idle();
    chk("R7 bit7 set", rd_data & 8'h80, 8'h80);
    step();
    chk("R10 alert low", {7'd0, alert_n}, 8'h00);

    cur_tag = "R3 write zero";
    w1c(8'h7C, 8'h00);
    chk("R3 zero keeps", rd_data & 8'h80, 8'h80);
    cur_tag = "R11 wrong cmd";
    w1c(8'h7B, 8'hFF);
    chk("R11 kept", rd_data & 8'h80, 8'h80);
    cur_tag = "R3 write one";
    w1c(8'h7C, 8'h80);
    chk("R3 cleared", rd_data & 8'h80, 8'h00);
    step();
    chk("R10 release", {7'd0, alert_n}, 8'h01);

    cur_tag = "R9 collide";
    ovf_evt = 1; clr_faults = 1; step(); idle();
    chk("R9 event wins", rd_data & 8'h80, 8'h80);

    cur_tag = "R6 arm";
    vin_on = 1; step(); step();
    uvw_evt = 1; step(); idle();
    chk("R6 armed sets", rd_data & 8'h20, 8'h20);
    vin_on = 0; step(); step();
    uvw_evt = 1; step(); idle();
    chk("R6 stays armed", rd_data & 8'h20, 8'h20);

    cur_tag = "R8 mask";
    mask_wr = 1; mask_wdata = 8'hA0; step(); idle(); step();
    chk("R8 masked alert", {7'd0, alert_n}, 8'h01);
    chk("R8 still latched", rd_data & 8'hA0, 8'hA0);

    cur_tag = "R4 clear";
    clr_faults = 1; step(); idle();
    chk("R4 both clear", rd_data & 8'hA0, 8'h00);
    mask_wr = 1; mask_wdata = 8'h00; step(); idle();

    cur_tag = "R12 low only";
    vin_on = 0; repeat (3) step();
    chk("R12 no alert", {7'd0, alert_n}, 8'h01);
    chk("R5 low set", rd_data & 8'h08, 8'h08);

    cur_tag = "random";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 15) == 0) vin_on = ~vin_on;
      ovf_evt    = ($urandom_range(0, 9) == 0);
      uvw_evt    = ($urandom_range(0, 7) == 0);
      clr_faults = ($urandom_range(0, 19) == 0);
      bus_wr     = ($urandom_range(0, 5) == 0);
      bus_cmd    = ($urandom_range(0, 3) != 0) ? 8'h7C : 8'($urandom);
      bus_wdata  = 8'($urandom);
      mask_wr    = ($urandom_range(0, 23) == 0);
      mask_wdata = 8'($urandom);
      step();
    end
    idle(); step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule